// File: doc/BRIEF.md
# Double-Buffered Sixteen-Channel Code Register Bank

This block is the digital front end of a sixteen-channel, 8-bit output converter that is driven from a parallel host bus. Each channel has two register stages. A staging register takes data from the bus, and a code register drives that channel's converter input. The host first writes staging registers one channel at a time, addressed by a 4-bit channel number. A single update strobe then moves every staged value into the code registers at the same moment, so all sixteen output levels change together. The host can read back any staging register to confirm what it wrote. An asynchronous clear input zeroes the code registers and leaves the staged data in place.

All bus controls are active low and level sensitive. While the enabling combination of controls is held, the selected register follows its source. It keeps its last value when that combination ends. The controls cross into the system clock domain through two-flop synchronizers, and transparency is produced by sampling on every clock while the combination holds. The bidirectional data bus appears as separate data-in, data-out and drive-enable ports. A channel code D stands for an output level of D × Vref / 256, so code 0xFF is one LSB below the reference.

Top module: `mdac_regbank`

## Requirements
- R1: After system reset, every channel code is 0x00 and the bus drive enable is low.
- R2: While select, strobe and direction (0 = write) are all low, the staging register chosen by the address follows the data input. A later read of that channel returns the written value.
- R3: Once the strobe or the select returns high, the staging register holds its value, and later changes on the data input have no effect on it.
- R4: A write changes only the addressed staging register. The other fifteen keep their contents.
- R5: Writes to staging registers leave every channel code unchanged while the update input is high.
- R6: While update and strobe are both low, every channel code takes the value of its own staging register, on the same clock for all channels, whatever the level of select.
- R7: With select, strobe, direction and update all low, both stages pass data through. A change on the data input reaches the addressed channel's code without any further control activity.
- R8: With direction high and select low, the drive enable is high and the data output carries the addressed staging register. With select high, the drive enable is low and the data output is 0x00.
- R9: A low level on the clear input forces every channel code to 0x00 at once, with no clock edge needed, and leaves all staging registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n_i | input | 1 | Asynchronous active-low clear of all channel codes |
| sel_n_i | input | 1 | Active-low chip select |
| stb_n_i | input | 1 | Active-low enable strobe |
| rnw_i | input | 1 | Direction: 1 = read, 0 = write |
| upd_n_i | input | 1 | Active-low update of all channel codes |
| addr_i | input | 4 | Channel number |
| din_i | input | 8 | Data from the host bus |
| dout_o | output | 8 | Readback data toward the host bus |
| dout_oe_o | output | 1 | Drive enable for the readback data |
| codes_o | output | 128 | Sixteen channel codes, channel n in bits 8n+7..8n |

## Verification
Every channel is written with a value computed from its number and the pass number. All values differ between channels and between passes, so a wrong address decode or a write that spills into another channel shows up as a mismatch on readback. The codes are checked before and after each update strobe, which separates an early transfer from a missing one. The second pass shows whether the codes still hold the first pass's values while the new data is staged. Separate patterns cover the fully transparent path, data changes after the strobe has closed, and a clear that is checked before any clock edge and then followed by a readback of the staged data.

// File: rtl/mdac_regbank_pkg.sv
package mdac_regbank_pkg;
  localparam int unsigned CH_COUNT = 16;
  localparam int unsigned CODE_W   = 8;

  typedef struct packed {
    logic upd_n;
    logic stb_n;
    logic rnw;
    logic sel_n;
  } bus_ctl_t;

  localparam int unsigned CTL_W = $bits(bus_ctl_t);
endpackage

// File: rtl/mdac_rst_sync.sv
module mdac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mdac_ctl_sync.sv
module mdac_ctl_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= IDLE;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mdac_chan_bank.sv
module mdac_chan_bank #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          in_rst_n,
  input  logic                          out_rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          xfer_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic [NUM_CH-1:0][DATA_W-1:0] codes
);
  logic [NUM_CH-1:0][DATA_W-1:0] stage_q, stage_d;
  logic [NUM_CH-1:0][DATA_W-1:0] code_q,  code_d;

  // staging stage: only the addressed channel follows the data
  always_comb begin
    stage_d = stage_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wr_en && (wr_addr == ADDR_W'(c))) stage_d[c] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge in_rst_n) begin
    if (!in_rst_n)  stage_q <= '0;
    else if (wr_en) stage_q <= stage_d;
  end

  // code stage: all channels move together
  always_comb begin
    code_d = stage_q;
  end

  always_ff @(posedge clk or negedge out_rst_n) begin
    if (!out_rst_n)   code_q <= '0;
    else if (xfer_en) code_q <= code_d;
  end

  assign rd_data = stage_q[rd_addr];
  assign codes   = code_q;

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!in_rst_n)
    wr_en |=> stage_q[$past(wr_addr)] == $past(wr_data));

  // R3
  stage_hold_chk: assert property (@(posedge clk) disable iff (!in_rst_n)
    !wr_en |=> $stable(stage_q));

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!out_rst_n)
    !xfer_en |=> $stable(code_q));

  // R6
  xfer_all_chk: assert property (@(posedge clk) disable iff (!out_rst_n || !in_rst_n)
    xfer_en |=> code_q == $past(stage_q));
endmodule

// File: rtl/mdac_regbank.sv
module mdac_regbank
  import mdac_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH      = CH_COUNT,
  parameter int unsigned DATA_W      = CODE_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_n_i,
  input  logic                     sel_n_i,
  input  logic                     stb_n_i,
  input  logic                     rnw_i,
  input  logic                     upd_n_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        din_i,
  output logic [DATA_W-1:0]        dout_o,
  output logic                     dout_oe_o,
  output logic [NUM_CH*DATA_W-1:0] codes_o
);
  logic      sys_rst_n;
  logic      code_rst_n;
  logic      code_arst_n;
  bus_ctl_t  ctl_raw, ctl_s;
  logic      wr_en, xfer_en, rd_en;
  logic [DATA_W-1:0]             rd_data;
  logic [NUM_CH-1:0][DATA_W-1:0] codes;

  assign code_arst_n = rst_n & clr_n_i;

  mdac_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(sys_rst_n)
  );

  mdac_rst_sync #(.STAGES(SYNC_STAGES)) u_code_rst (
    .clk(clk), .arst_n(code_arst_n), .srst_n(code_rst_n)
  );

  assign ctl_raw = '{upd_n: upd_n_i, stb_n: stb_n_i, rnw: rnw_i, sel_n: sel_n_i};

  mdac_ctl_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .IDLE('1)) u_ctl_sync (
    .clk(clk), .rst_n(sys_rst_n), .async_i(ctl_raw), .sync_o(ctl_s)
  );

  always_comb begin
    wr_en   = !ctl_s.sel_n && !ctl_s.stb_n && !ctl_s.rnw;
    xfer_en = !ctl_s.upd_n && !ctl_s.stb_n;
    rd_en   = !ctl_s.sel_n &&  ctl_s.rnw;
  end

  mdac_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .in_rst_n(sys_rst_n), .out_rst_n(code_rst_n),
    .wr_en(wr_en), .wr_addr(addr_i), .wr_data(din_i),
    .xfer_en(xfer_en), .rd_addr(addr_i), .rd_data(rd_data),
    .codes(codes)
  );

  assign dout_oe_o = rd_en;
  assign dout_o    = rd_en ? rd_data : '0;
  assign codes_o   = codes;

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_i |-> codes_o == '0);

  // R8
  bus_idle_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !dout_oe_o |-> dout_o == '0);
endmodule

// File: tb/mdac_regbank_test.sv
module mdac_regbank_test;
  localparam int NCH = 16;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n, clr_n, sel_n, stb_n, rnw, upd_n;
  logic [3:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic oe;
  logic [NCH*DW-1:0] codes;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  mdac_regbank uut (
    .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n), .sel_n_i(sel_n),
    .stb_n_i(stb_n), .rnw_i(rnw), .upd_n_i(upd_n), .addr_i(addr),
    .din_i(din), .dout_o(dout), .dout_oe_o(oe), .codes_o(codes)
  );

  function automatic logic [7:0] pat(int ch, int pass);
    return 8'((ch * 37 + pass * 91 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, logic [7:0] v);
    addr = 4'(ch); din = v; rnw = 1'b0; sel_n = 1'b0;
    waitn(1);
    stb_n = 1'b0; waitn(4);
    stb_n = 1'b1; waitn(4);
    sel_n = 1'b1; rnw = 1'b1; waitn(3);
  endtask

  task automatic rd_chk(string req, int ch, logic [7:0] exp);
    addr = 4'(ch); rnw = 1'b1; sel_n = 1'b0;
    waitn(4);
    chk(req, {31'd0, oe}, 32'd1);
    chk(req, {24'd0, dout}, {24'd0, exp});
    sel_n = 1'b1; waitn(3);
  endtask

  task automatic update;
    upd_n = 1'b0; stb_n = 1'b0; waitn(4);
    upd_n = 1'b1; stb_n = 1'b1; waitn(4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; sel_n = 1'b1; stb_n = 1'b1;
    rnw = 1'b1; upd_n = 1'b1; addr = '0; din = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(5);
    // R1 reset state
    chk("R1 codes", {31'd0, codes == '0}, 32'd1);
    chk("R1 oe", {31'd0, oe}, 32'd0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int ch = 0; ch < NCH; ch++) wr(ch, pat(ch, pass));
      // R2 / R4: each channel holds its own value
      for (int ch = 0; ch < NCH; ch++) rd_chk("R2/R4 readback", ch, pat(ch, pass));
      // R5: codes unchanged by writes
      for (int ch = 0; ch < NCH; ch++)
        chk("R5 codes held", {24'd0, codes[ch*DW +: DW]},
            {24'd0, (pass == 0) ? 8'h00 : pat(ch, 0)});
      update;
      // R6: all codes now match staging
      for (int ch = 0; ch < NCH; ch++)
        chk("R6 update", {24'd0, codes[ch*DW +: DW]}, {24'd0, pat(ch, pass)});
    end

    // R3: data change after strobe closes is ignored
    wr(3, 8'hFF);
    din = 8'h5A; waitn(4);
    sel_n = 1'b0; rnw = 1'b0; waitn(4);   // select low, strobe high
    din = 8'hA5; waitn(4);
    sel_n = 1'b1; rnw = 1'b1; waitn(3);
    rd_chk("R3 hold", 3, 8'hFF);
    rd_chk("R3 neighbour", 4, pat(4, 1));

    // R8: deselected bus
    sel_n = 1'b1; rnw = 1'b1; waitn(4);
    chk("R8 oe off", {31'd0, oe}, 32'd0);
    chk("R8 dout zero", {24'd0, dout}, 32'd0);

    // R7: fully transparent path
    addr = 4'd5; din = 8'h3C; rnw = 1'b0; sel_n = 1'b0; upd_n = 1'b0; stb_n = 1'b0;
    waitn(6);
    chk("R7 pass 3C", {24'd0, codes[5*DW +: DW]}, 32'h3C);
    din = 8'hC3; waitn(4);
    chk("R7 pass C3", {24'd0, codes[5*DW +: DW]}, 32'hC3);
    din = 8'h00; waitn(4);
    chk("R7 pass 00", {24'd0, codes[5*DW +: DW]}, 32'h00);
    chk("R7 other ch", {24'd0, codes[6*DW +: DW]}, {24'd0, pat(6, 1)});
    stb_n = 1'b1; waitn(2);
    sel_n = 1'b1; rnw = 1'b1; upd_n = 1'b1; waitn(3);

    // R9: asynchronous clear
    wr(5, 8'h81);
    update;
    chk("R9 before", {24'd0, codes[5*DW +: DW]}, 32'h81);
    @(posedge clk); #1;
    clr_n = 1'b0; #1;
    chk("R9 immediate", {31'd0, codes == '0}, 32'd1);
    waitn(3);
    clr_n = 1'b1; waitn(4);
    chk("R9 still zero", {31'd0, codes == '0}, 32'd1);
    rd_chk("R9 staging kept", 5, 8'h81);
    rd_chk("R9 staging kept", 3, 8'hFF);
    rd_chk("R9 staging kept", 15, pat(15, 1));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule